// File: doc/BRIEF.md
# Timer Match Control Unit

A free-running 32-bit up-counter with a programmable prescaler and four match channels. The prescaler counts clock cycles from zero up to a programmable limit, then wraps and advances the main counter by one. Each match channel compares its match register against the main counter at the prescaler wrap point. On equality it can raise a sticky interrupt flag, clear the counter, or halt counting. Any combination of these actions can be selected per channel.

Each match register sits behind a shadow register. When a channel's reload enable is set, the match register takes the shadow value every time the counter is returned to zero. A match-triggered clear causes this, and so does a software counter reset. Software therefore can change the period or compare point without a race against the running count. All configuration goes through a simple single-cycle write port.

Top module: `match_timer`

## Requirements
- R1: After reset the counter is 0, the run state is 0, and all interrupt flags and the interrupt output are 0.
- R2: With the enable bit (address 0, bit 0) at 1 and a prescale limit P (address 2), the counter advances by one every P+1 clock cycles.
- R3: While bit 1 at address 0 is 1, the counter and prescaler are held at zero. Counting resumes once it is written back to 0.
- R4: Channel n's interrupt bit is bit 3n of the control word at address 1. When it is set and match register n equals the counter at the prescaler wrap, flag n is set. The interrupt output is the OR of the flags.
- R5: Flags stay set until a write to address 3 with a 1 in bit n clears flag n. A 0 in that bit leaves flag n unchanged.
- R6: Channel n's reset bit is bit 3n+1. When it is set and a match occurs, the counter goes to 0 instead of the match value plus one.
- R7: Channel n's stop bit is bit 3n+2. When it is set and a match occurs, the counter and prescaler halt and the run state (enable bit) clears.
- R8: A match that has both reset and stop set leaves the counter held at 0 with the run state cleared.
- R9: Channel n's reload enable is bit 24+n. When it is set, a match-triggered counter clear loads match register n (address 4+n) from shadow register n (address 8+n).
- R10: When the reload enable is set, a software counter reset (address 0, bit 1) also loads the match register from its shadow.
- R11: With the reload enable clear, shadow writes never change the match value used for comparison.
- R12: Channels that match in the same cycle all apply their actions; every enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| count | output | 32 | Main counter value |
| running | output | 1 | Enable bit (cleared by a stop match) |
| irq_flags | output | 4 | Per-channel sticky interrupt flags |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The hardest case to reach from the ports is a reload whose effect can only be seen later: the match register cannot be read, so the new shadow value is visible only as a changed period on the next count cycle. The directed tests first set a match value and a different shadow value. They then check the counter at the cycle where the old and new periods would diverge, once for a match-triggered clear and once for a software counter reset. Random phases mix small match values, small prescale limits and random control words. This makes coincident matches, reset-plus-stop, and reloads during a software hold happen often, and a per-cycle model follows them.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTLWORD = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC   = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAGCLR = 4'd3;
  localparam logic [ADDR_W-1:0] A_MATCH0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SHADOW0 = 4'd8;

  localparam int BITS_PER_CH = 3;
  localparam int RELOAD_LSB  = 24;

  typedef struct packed {
    logic irq_en;
    logic rst_en;
    logic stop_en;
    logic reload_en;
  } chan_ctl_t;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold_zero,
  input  logic             wr_limit,
  input  logic [CNT_W-1:0] wr_val,
  output logic             tick
);
  logic [CNT_W-1:0] pc_q;
  logic [CNT_W-1:0] limit_q;

  assign tick = run && (pc_q >= limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      limit_q <= '0;
    end else begin
      if (wr_limit) limit_q <= wr_val;
      if (hold_zero)  pc_q <= '0;
      else if (run)   pc_q <= tick ? '0 : pc_q + 1'b1;
    end
  end

  // R3
  presc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold_zero |=> (pc_q == '0));

  // R2
  presc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold_zero) |=> $stable(pc_q));
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_match,
  input  logic              wr_shadow,
  input  logic [CNT_W-1:0]  wr_val,
  input  logic [CNT_W-1:0]  tc,
  input  logic              tick,
  input  mt_pkg::chan_ctl_t ctl,
  input  logic              zero_evt,
  input  logic              flag_clr,
  output logic              hit_rst,
  output logic              hit_stop,
  output logic              flag
);
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] shadow_q;
  logic             hit;

  assign hit      = tick && (match_q == tc);
  assign hit_rst  = hit && ctl.rst_en;
  assign hit_stop = hit && ctl.stop_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= '0;
      shadow_q <= '0;
      flag     <= 1'b0;
    end else begin
      if (wr_shadow) shadow_q <= wr_val;
      if (wr_match)                        match_q <= wr_val;
      else if (zero_evt && ctl.reload_en)  match_q <= shadow_q;
      if (hit && ctl.irq_en) flag <= 1'b1;
      else if (flag_clr)     flag <= 1'b0;
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && ctl.irq_en) |=> flag);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && ctl.reload_en && !wr_match) |=> (match_q == $past(shadow_q)));

  // R11
  no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.reload_en && !wr_match) |=> $stable(match_q));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic [N_CH-1:0]  irq_flags,
  output logic             irq
);
  import mt_pkg::*;

  logic             en_q;
  logic             crst_q;
  logic [CNT_W-1:0] tc_q;
  logic             tick;
  logic             wr_ctrl;
  logic             zero_evt;
  logic [N_CH-1:0]  hit_rst;
  logic [N_CH-1:0]  hit_stop;
  logic [N_CH-1:0]  flag_vec;
  chan_ctl_t        ctl_q [N_CH];

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign zero_evt = crst_q || (tick && |hit_rst);

  mt_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .run       (en_q && !crst_q),
    .hold_zero (crst_q),
    .wr_limit  (wr_en && (wr_addr == A_PRESC)),
    .wr_val    (wr_data),
    .tick      (tick)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    localparam logic [3:0] MADDR = A_MATCH0 + 4'(n);
    localparam logic [3:0] SADDR = A_SHADOW0 + 4'(n);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[n] <= '0;
      end else if (wr_en && (wr_addr == A_CTLWORD)) begin
        ctl_q[n].irq_en    <= wr_data[BITS_PER_CH*n];
        ctl_q[n].rst_en    <= wr_data[BITS_PER_CH*n+1];
        ctl_q[n].stop_en   <= wr_data[BITS_PER_CH*n+2];
        ctl_q[n].reload_en <= wr_data[RELOAD_LSB+n];
      end
    end

    mt_match_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_match  (wr_en && (wr_addr == MADDR)),
      .wr_shadow (wr_en && (wr_addr == SADDR)),
      .wr_val    (wr_data),
      .tc        (tc_q),
      .tick      (tick),
      .ctl       (ctl_q[n]),
      .zero_evt  (zero_evt),
      .flag_clr  (wr_en && (wr_addr == A_FLAGCLR) && wr_data[n]),
      .hit_rst   (hit_rst[n]),
      .hit_stop  (hit_stop[n]),
      .flag      (flag_vec[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      crst_q <= 1'b0;
      tc_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data[0];
        crst_q <= wr_data[1];
      end else if (tick && |hit_stop) begin
        en_q <= 1'b0;
      end
      if (crst_q)             tc_q <= '0;
      else if (tick) begin
        if (|hit_rst)         tc_q <= '0;
        else if (!(|hit_stop)) tc_q <= tc_q + 1'b1;
      end
    end
  end

  assign count     = tc_q;
  assign running   = en_q;
  assign irq_flags = flag_vec;
  assign irq       = |flag_vec;

  // R3
  crst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    crst_q |=> (tc_q == '0));

  // R6
  match_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && |hit_rst) |=> (tc_q == '0));

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && |hit_stop && !wr_ctrl) |=> !en_q);

  // R7
  halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !crst_q) |=> $stable(tc_q));

  // R8
  rst_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && |hit_rst && |hit_stop && !wr_ctrl) |=> (tc_q == '0 && !en_q));
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] count;
  logic        running;
  logic [3:0]  irq_flags;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_tc, m_pc, m_pr;
  logic        m_en, m_crst;
  logic [31:0] m_cw;
  logic [31:0] m_match [NC];
  logic [31:0] m_shadow [NC];
  logic [3:0]  m_flags;

  match_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .running(running), .irq_flags(irq_flags), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tc = 0; m_pc = 0; m_pr = 0; m_en = 0; m_crst = 0; m_cw = 0; m_flags = 0;
    for (int n = 0; n < NC; n++) begin m_match[n] = 0; m_shadow[n] = 0; end
  endtask

  task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d);
    logic tick, anyr, anys, reload;
    logic [3:0] hit;
    logic [31:0] ntc, npc;
    tick = m_en && !m_crst && (m_pc >= m_pr);
    for (int n = 0; n < NC; n++) hit[n] = tick && (m_match[n] == m_tc);
    anyr = 0; anys = 0;
    for (int n = 0; n < NC; n++) begin
      anyr |= hit[n] & m_cw[3*n+1];
      anys |= hit[n] & m_cw[3*n+2];
    end
    reload = m_crst || (tick && anyr);
    npc = m_crst ? 0 : (m_en ? (tick ? 0 : m_pc + 1) : m_pc);
    ntc = m_crst ? 0 : (tick ? (anyr ? 0 : (anys ? m_tc : m_tc + 1)) : m_tc);
    for (int n = 0; n < NC; n++) begin
      if (hit[n] && m_cw[3*n]) m_flags[n] = 1'b1;
      else if (we && a == 4'd3 && d[n]) m_flags[n] = 1'b0;
      if (we && a == 4'(4 + n)) m_match[n] = d;
      else if (reload && m_cw[24+n]) m_match[n] = m_shadow[n];
      if (we && a == 4'(8 + n)) m_shadow[n] = d;
    end
    if (we && a == 4'd0) begin m_en = d[0]; m_crst = d[1]; end
    else if (tick && anys) m_en = 0;
    if (we && a == 4'd1) m_cw = d;
    if (we && a == 4'd2) m_pr = d;
    m_tc = ntc; m_pc = npc;
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    model_step(we, a, d);
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    checks++;
    if (count !== m_tc || running !== m_en || irq_flags !== m_flags || irq !== |m_flags) begin
      errors++;
      $display("FAIL model R2/R4/R7 actual tc=%0h en=%0b fl=%0h expected tc=%0h en=%0b fl=%0h",
               count, running, irq_flags, m_tc, m_en, m_flags);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d); step(1'b1, a, d); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0); endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 count", count, 0); chk("R1 running", {31'd0, running}, 0);
    chk("R1 flags", {28'd0, irq_flags}, 0); chk("R1 irq", {31'd0, irq}, 0);

    // R2: limit 2 -> one count per 3 cycles
    wr(4'd2, 2); wr(4'd0, 1); idle(9);
    chk("R2 count after 9 cycles", count, 3);

    // R3
    wr(4'd0, 3); idle(4);
    chk("R3 held at zero", count, 0);
    wr(4'd0, 1); idle(3);
    chk("R3 resumes", count, 1);

    // R4 / R12 / R5
    do_reset();
    wr(4'd4, 3); wr(4'd5, 3); wr(4'd1, 32'h9); wr(4'd0, 1); idle(4);
    chk("R12 both flags", {28'd0, irq_flags}, 4'b0011);
    chk("R4 irq", {31'd0, irq}, 1);
    wr(4'd3, 1);
    chk("R5 clear bit0", {28'd0, irq_flags}, 4'b0010);
    wr(4'd3, 0);
    chk("R5 zero write ignored", {28'd0, irq_flags}, 4'b0010);
    wr(4'd3, 2);
    chk("R5 clear bit1 irq", {31'd0, irq}, 0);

    // R6
    do_reset();
    wr(4'd4, 4); wr(4'd1, 32'h2); wr(4'd0, 1); idle(5);
    chk("R6 cleared at match", count, 0);
    idle(1);
    chk("R6 counts again", count, 1);

    // R7
    do_reset();
    wr(4'd2, 1); wr(4'd5, 2); wr(4'd1, 32'h20); wr(4'd0, 1); idle(6);
    chk("R7 stopped", {31'd0, running}, 0);
    chk("R7 count held", count, 2);
    idle(5);
    chk("R7 still held", count, 2);

    // R8
    do_reset();
    wr(4'd6, 3); wr(4'd1, 32'h180); wr(4'd0, 1); idle(4);
    chk("R8 zero", count, 0); chk("R8 stopped", {31'd0, running}, 0);
    idle(3);
    chk("R8 holds zero", count, 0);

    // R9
    do_reset();
    wr(4'd4, 5); wr(4'd8, 2); wr(4'd1, 32'h0100_0002); wr(4'd0, 1); idle(6);
    chk("R9 first clear", count, 0);
    idle(2); chk("R9 new period", count, 2);
    idle(1); chk("R9 reloaded match", count, 0);

    // R10
    do_reset();
    wr(4'd4, 10); wr(4'd8, 2); wr(4'd1, 32'h0100_0002); wr(4'd0, 3); wr(4'd0, 1);
    idle(2); chk("R10 count", count, 2);
    idle(1); chk("R10 reloaded by sw reset", count, 0);

    // R11
    do_reset();
    wr(4'd4, 3); wr(4'd8, 1); wr(4'd1, 32'h2); wr(4'd0, 1); idle(7);
    chk("R11 shadow ignored", count, 3);
    wr(4'd8, 0); idle(1);
    chk("R11 old match kept", count, 1);

    // constrained random against the model
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 16 < 3) begin
        logic [3:0] a;
        logic [31:0] d;
        a = 4'($urandom % 12);
        case (a)
          4'd0:    d = ($urandom % 6 == 0) ? 32'd3 : (($urandom % 8 == 0) ? 32'd0 : 32'd1);
          4'd1:    d = $urandom & 32'h0F00_0FFF;
          4'd2:    d = $urandom % 3;
          4'd3:    d = $urandom % 16;
          default: d = $urandom % 12;
        endcase
        step(1'b1, a, d);
      end else begin
        step(1'b0, 4'd0, 32'd0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule